// File: doc/BRIEF.md
# Two-Wire EEPROM Page Write Target

This block is the receiving side of a two-wire serial EEPROM, limited to the write path. It watches the clock and data lines, pulls the data line low to acknowledge, and recognises bus Start and Stop conditions. A write transfer consists of a Start, a select byte, one word address, and then up to a page worth of data bytes. The data bytes are gathered into a small page buffer. A Stop placed correctly after the final acknowledge copies the received bytes into a 256-byte storage array. The copy is followed by a timed busy window in which the block ignores the bus entirely.

A write-control input blocks writes. The block samples it from the Start until the address byte is complete. While it has been seen high, data bytes are refused and nothing is stored. A combinational debug port reads any byte of the array, so the stored contents can be inspected without a bus read path.

Top module: `eeprom_page_writer`

## Requirements
- R1: The select byte is acknowledged only when its upper four bits are 1010, bits 3..1 equal `strap_i` and bit 0 (the read/write flag) is 0. Any other select byte gets no acknowledge, and the block ignores the bus until the next Start.
- R2: The address byte after an accepted select is always acknowledged. Its bits 7..4 pick the 16-byte page and its bits 3..0 give the first offset within that page.
- R3: With writes allowed, every data byte is acknowledged and buffered at consecutive offsets. A Stop during the clock slot that follows a data acknowledge commits the buffer to the array.
- R4: A Stop in any other slot, for example in the middle of a data byte, discards the buffered bytes. Nothing is written and busy stays low.
- R5: If `wc_i` is high at any time from the Start through the end of the address byte, every data byte gets no acknowledge and the array is left unchanged. `wc_i` has no effect once the address byte is complete.
- R6: The offset wraps from 15 to 0 inside the same page. A later byte at the same offset replaces the earlier one.
- R7: A commit changes only the offsets that received a byte. All other bytes of the page keep their previous values.
- R8: After a commit, `busy_o` is high for exactly `BUSY_CYCLES` consecutive clock cycles.
- R9: While `busy_o` is high the block never pulls SDA, even for its own select byte, and no bytes sent during that window are stored.
- R10: A repeated Start before the Stop abandons the current transfer without writing anything, and reception restarts with a select byte.
- R11: After reset `busy_o` and `sda_pull_o` are low and every array byte reads 0.
- R12: `dbg_data_o` shows the array byte at `dbg_addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | High to pull the data line low (acknowledge) |
| wc_i | input | 1 | Write-control; high blocks writes |
| strap_i | input | 3 | Device address strap bits |
| busy_o | output | 1 | High during the internal write window |
| dbg_addr_i | input | 8 | Debug read address |
| dbg_data_o | output | 8 | Array byte at the debug address |

## Verification
The hardest case is placing the Stop in the right slot. The Stop's own clock rise is counted as the first bit of the next byte, so the bench's bus model sends complete data bytes followed by a Stop in the slot after the acknowledge. It also sends a byte cut off after three bits and then a Stop, and the two must produce opposite results. The busy window is made long enough that the bench can send a full Start and select byte while the window is still open. It then checks that the select gets no acknowledge and that the array is unchanged afterwards.

// File: rtl/eewr_pkg.sv
package eewr_pkg;
   localparam int BYTE_W = 8;
   localparam logic [3:0] DEV_TYPE = 4'b1010;
   typedef enum logic [1:0] {ST_IDLE, ST_SEL, ST_ADDR, ST_DATA} wr_state_e;
endpackage

// File: rtl/eewr_sync.sv
module eewr_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("eewr_sync needs at least two stages");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("eewr_sync needs a positive width");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '1;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eewr_cond.sv
module eewr_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise_o = scl_s & ~scl_q;
   assign scl_fall_o = ~scl_s & scl_q;
   assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eewr_ctrl.sv
module eewr_ctrl
   import eewr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 4,
   parameter int SEL_W  = 3,
   localparam int LANES = 1 << PAGE_W,
   localparam int PG_W  = ADDR_W - PAGE_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_rise_i,
   input  logic                    scl_fall_i,
   input  logic                    start_i,
   input  logic                    stop_i,
   input  logic                    sda_s,
   input  logic                    wc_i,
   input  logic [SEL_W-1:0]        strap_i,
   input  logic                    busy_i,
   output logic                    sda_pull_o,
   output logic                    commit_o,
   output logic [PG_W-1:0]         page_o,
   output logic [LANES-1:0]        mask_o,
   output logic [LANES*BYTE_W-1:0] data_o,
   output logic                    wp_o
);
   if (SEL_W + 5 != BYTE_W) begin : g_bad_sel
      $error("select byte layout needs SEL_W == 3");
   end
   if (ADDR_W != BYTE_W) begin : g_bad_addr
      $error("one address byte must cover the array");
   end

   wr_state_e          state_q;
   logic [BYTE_W-1:0]  shreg_q;
   logic [3:0]         bcnt_q;
   logic               ack_ph_q, ack_drv_q, wp_q, commit_q;
   logic [PG_W-1:0]    page_q;
   logic [PAGE_W-1:0]  offs_q;
   logic [LANES-1:0]   mask_q;
   logic [BYTE_W-1:0]  lane_q [LANES];
   logic               sel_ok;

   assign sel_ok = (shreg_q[7:4] == DEV_TYPE) && (shreg_q[SEL_W:1] == strap_i) && !shreg_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         shreg_q   <= '0;
         bcnt_q    <= '0;
         ack_ph_q  <= 1'b0;
         ack_drv_q <= 1'b0;
         wp_q      <= 1'b0;
         commit_q  <= 1'b0;
         page_q    <= '0;
         offs_q    <= '0;
         mask_q    <= '0;
         for (int l = 0; l < LANES; l++) lane_q[l] <= '0;
      end else begin
         commit_q <= 1'b0;
         if (busy_i) begin
            state_q   <= ST_IDLE;
            ack_ph_q  <= 1'b0;
            ack_drv_q <= 1'b0;
         end else if (start_i) begin
            state_q   <= ST_SEL;
            bcnt_q    <= '0;
            ack_ph_q  <= 1'b0;
            ack_drv_q <= 1'b0;
            mask_q    <= '0;
            wp_q      <= wc_i;
         end else if (stop_i) begin
            commit_q  <= (state_q == ST_DATA) && !ack_ph_q && (bcnt_q == 4'd1) &&
                         !wp_q && (mask_q != '0);
            state_q   <= ST_IDLE;
            ack_ph_q  <= 1'b0;
            ack_drv_q <= 1'b0;
         end else if (state_q != ST_IDLE) begin
            if ((state_q == ST_SEL || state_q == ST_ADDR) && wc_i) wp_q <= 1'b1;
            if (ack_ph_q) begin
               if (scl_fall_i) begin
                  ack_ph_q  <= 1'b0;
                  ack_drv_q <= 1'b0;
                  bcnt_q    <= '0;
               end
            end else if (scl_rise_i && bcnt_q < 4'd8) begin
               shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
               bcnt_q  <= bcnt_q + 4'd1;
            end else if (scl_fall_i && bcnt_q == 4'd8) begin
               unique case (state_q)
                  ST_SEL: begin
                     if (sel_ok) begin
                        ack_ph_q  <= 1'b1;
                        ack_drv_q <= 1'b1;
                        state_q   <= ST_ADDR;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
                  ST_ADDR: begin
                     ack_ph_q  <= 1'b1;
                     ack_drv_q <= 1'b1;
                     page_q    <= shreg_q[ADDR_W-1:PAGE_W];
                     offs_q    <= shreg_q[PAGE_W-1:0];
                     state_q   <= ST_DATA;
                  end
                  default: begin
                     ack_ph_q  <= 1'b1;
                     ack_drv_q <= !wp_q;
                     if (!wp_q) begin
                        lane_q[offs_q] <= shreg_q;
                        mask_q[offs_q] <= 1'b1;
                        offs_q         <= offs_q + PAGE_W'(1);
                     end
                  end
               endcase
            end
         end
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign data_o[l*BYTE_W +: BYTE_W] = lane_q[l];
   end

   assign sda_pull_o = ack_drv_q;
   assign commit_o   = commit_q;
   assign page_o     = page_q;
   assign mask_o     = mask_q;
   assign wp_o       = wp_q;
endmodule

// File: rtl/eewr_store.sv
module eewr_store
   import eewr_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int PAGE_W      = 4,
   parameter int BUSY_CYCLES = 200,
   localparam int LANES = 1 << PAGE_W,
   localparam int PG_W  = ADDR_W - PAGE_W,
   localparam int DEPTH = 1 << ADDR_W,
   localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    commit_i,
   input  logic [PG_W-1:0]         page_i,
   input  logic [LANES-1:0]        mask_i,
   input  logic [LANES*BYTE_W-1:0] data_i,
   input  logic [ADDR_W-1:0]       rd_addr_i,
   output logic [BYTE_W-1:0]       rd_data_o,
   output logic                    busy_o
);
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("BUSY_CYCLES must be at least 1");
   end
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("PAGE_W must lie between 1 and ADDR_W-1");
   end

   logic [BYTE_W-1:0] mem_q [DEPTH];
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
      end else if (commit_i) begin
         for (int l = 0; l < LANES; l++) begin
            if (mask_i[l]) mem_q[{page_i, PAGE_W'(l)}] <= data_i[l*BYTE_W +: BYTE_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (commit_i)       cnt_q <= CNT_W'(BUSY_CYCLES);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign busy_o    = (cnt_q != '0);
   assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
   import eewr_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int PAGE_W      = 4,
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter int BUSY_CYCLES = 200,
   localparam int LANES = 1 << PAGE_W,
   localparam int PG_W  = ADDR_W - PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   input  logic              wc_i,
   input  logic [SEL_W-1:0]  strap_i,
   output logic              busy_o,
   input  logic [ADDR_W-1:0] dbg_addr_i,
   output logic [BYTE_W-1:0] dbg_data_o
);
   logic                    scl_s, sda_s;
   logic                    rise_w, fall_w, start_w, stop_w;
   logic                    commit_w, prot_w;
   logic [PG_W-1:0]         page_w;
   logic [LANES-1:0]        mask_w;
   logic [LANES*BYTE_W-1:0] data_w;

   eewr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
   );

   eewr_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise_o(rise_w), .scl_fall_o(fall_w), .start_o(start_w), .stop_o(stop_w)
   );

   eewr_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SEL_W(SEL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_rise_i(rise_w), .scl_fall_i(fall_w),
      .start_i(start_w), .stop_i(stop_w), .sda_s(sda_s), .wc_i(wc_i),
      .strap_i(strap_i), .busy_i(busy_o), .sda_pull_o(sda_pull_o),
      .commit_o(commit_w), .page_o(page_w), .mask_o(mask_w), .data_o(data_w),
      .wp_o(prot_w)
   );

   eewr_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
      .clk(clk), .rst_n(rst_n), .commit_i(commit_w), .page_i(page_w),
      .mask_i(mask_w), .data_i(data_w), .rd_addr_i(dbg_addr_i),
      .rd_data_o(dbg_data_o), .busy_o(busy_o)
   );
endmodule

// File: rtl/eewr_chk.sv
module eewr_chk #(
   parameter int LANES       = 16,
   parameter int BUSY_CYCLES = 200
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy_o,
   input logic             sda_pull_o,
   input logic             commit_w,
   input logic             prot_w,
   input logic             fall_w,
   input logic [LANES-1:0] mask_w
);
   int run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= 0;
      else if (busy_o) run_q <= run_q + 1;
      else             run_q <= 0;
   end

   // R8
   busy_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> run_q < BUSY_CYCLES);

   // R8
   busy_len_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> run_q == BUSY_CYCLES);

   // R9
   deaf_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !sda_pull_o);

   // R1
   ack_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> $past(fall_w));

   // R5
   commit_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_w |-> !prot_w && mask_w != '0);

   // R3
   commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_w |=> busy_o);
endmodule

bind eeprom_page_writer eewr_chk #(.LANES(LANES), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .sda_pull_o(sda_pull_o),
   .commit_w(commit_w), .prot_w(prot_w), .fall_w(fall_w), .mask_w(mask_w)
);

// File: tb/eeprom_page_writer_bench.sv
module eeprom_page_writer_bench;
   localparam int BUSY = 600;
   localparam int Q    = 8;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] SEL   = {4'b1010, STRAP, 1'b0};

   logic clk = 0, rst_n = 0;
   logic scl_m = 1, sda_m = 1, wc = 0;
   logic [7:0] dbg_addr = 0;
   logic [7:0] dbg_data;
   logic sda_pull, busy, sda_w;

   always #4 clk = ~clk;
   assign sda_w = sda_m & ~sda_pull;

   eeprom_page_writer #(.BUSY_CYCLES(BUSY)) u_eeprom_page_writer (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_w), .sda_pull_o(sda_pull),
      .wc_i(wc), .strap_i(STRAP), .busy_o(busy), .dbg_addr_i(dbg_addr),
      .dbg_data_o(dbg_data)
   );

   int n_chk = 0, n_fail = 0;
   int run = 0, last_len = 0;
   logic [7:0] model [256];
   typedef struct { logic [7:0] addr; logic [7:0] data; string tag; } exp_t;
   exp_t sb_q [$];
   bit mon_act = 0;

   always @(negedge clk) begin
      if (busy) run <= run + 1;
      else begin
         if (run != 0) last_len <= run;
         run <= 0;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_eq(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
      end
   endtask

   task automatic xfer(input logic [7:0] b, output logic acked);
      send_bits(b, 8);
      sda_m = 1; tick(Q); scl_m = 1; tick(Q);
      acked = !sda_w;
      tick(Q); scl_m = 0; tick(Q);
   endtask

   task automatic push_page(input logic [3:0] pg, input string tag);
      for (int l = 0; l < 16; l++) begin
         exp_t e;
         e.addr = {pg, 4'(l)};
         e.data = model[{pg, 4'(l)}];
         e.tag  = tag;
         sb_q.push_back(e);
      end
      wait (sb_q.size() == 0 && !mon_act);
   endtask

   // full write; exp_ack tells whether data bytes should be taken
   task automatic page_write(input logic [7:0] a, input int n, input logic [7:0] v0,
                             input bit exp_ack, input string tag);
      logic ack;
      bus_start();
      xfer(SEL, ack);  check_eq({tag, " R1 sel ack"}, ack, 1);
      xfer(a, ack);    check_eq({tag, " R2 addr ack"}, ack, 1);
      for (int k = 0; k < n; k++) begin
         xfer(v0 + 8'(k), ack);
         check_eq({tag, " data ack"}, ack, exp_ack);
         if (exp_ack) model[{a[7:4], 4'(a[3:0] + 4'(k))}] = v0 + 8'(k);
      end
      bus_stop();
      tick(4);
      check_eq({tag, " busy after stop"}, busy, exp_ack);
      wait (!busy);
      tick(2);
   endtask

   initial begin
      forever begin
         exp_t it;
         wait (sb_q.size() != 0);
         mon_act = 1;
         it = sb_q.pop_front();
         dbg_addr = it.addr;
         tick(1);
         check_eq({it.tag, " R12 mem"}, dbg_data, it.data);
         mon_act = 0;
         tick(1);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic ack;
      for (int a = 0; a < 256; a++) model[a] = 8'h00;
      tick(3); rst_n = 1; tick(2);
      // R11 reset state
      check_eq("R11 busy", busy, 0);
      check_eq("R11 pull", sda_pull, 0);
      push_page(4'h2, "R11 zero");

      // R3 byte write, R8 busy length
      page_write(8'h23, 1, 8'hA5, 1, "R3 byte");
      check_eq("R8 busy length", last_len, BUSY);
      push_page(4'h2, "R3 byte");

      // R7 partial page
      page_write(8'h30, 5, 8'h50, 1, "R7 page");
      push_page(4'h3, "R7 page");

      // R6 wrap inside page
      page_write(8'h4E, 4, 8'h10, 1, "R6 wrap");
      push_page(4'h4, "R6 wrap");
      push_page(4'h5, "R6 next page");
      page_write(8'h60, 18, 8'h80, 1, "R6 overrun");
      push_page(4'h6, "R6 overrun");

      // R5 write-control during select only
      wc = 1; bus_start(); xfer(SEL, ack); wc = 0;
      xfer(8'h30, ack); check_eq("R5 addr ack", ack, 1);
      xfer(8'hEE, ack); check_eq("R5 sel-wc data nak", ack, 0);
      bus_stop(); tick(4); check_eq("R5 no busy", busy, 0);
      // R5 write-control during address only
      bus_start(); xfer(SEL, ack); wc = 1; xfer(8'h31, ack); wc = 0;
      xfer(8'hEE, ack); check_eq("R5 addr-wc data nak", ack, 0);
      bus_stop(); tick(4); check_eq("R5 no busy 2", busy, 0);
      push_page(4'h3, "R5 unchanged");
      // R5 write-control during data has no effect
      bus_start(); xfer(SEL, ack); xfer(8'h38, ack); wc = 1;
      xfer(8'h3C, ack); check_eq("R5 late wc ack", ack, 1);
      wc = 0; bus_stop(); model[8'h38] = 8'h3C;
      tick(4); check_eq("R5 late wc busy", busy, 1);
      wait (!busy); tick(2);
      push_page(4'h3, "R5 late wc");

      // R1 wrong strap and read flag
      bus_start(); xfer({4'b1010, 3'b100, 1'b0}, ack); check_eq("R1 strap nak", ack, 0);
      xfer(8'h70, ack); check_eq("R1 idle after nak", ack, 0);
      xfer(8'h12, ack); bus_stop(); tick(4); check_eq("R1 no busy", busy, 0);
      bus_start(); xfer({SEL[7:1], 1'b1}, ack); check_eq("R1 read flag nak", ack, 0);
      bus_stop(); tick(4);
      push_page(4'h7, "R1 unchanged");

      // R4 stop inside a byte
      bus_start(); xfer(SEL, ack); xfer(8'h72, ack); xfer(8'h99, ack);
      send_bits(8'h00, 3); bus_stop(); tick(4);
      check_eq("R4 no busy", busy, 0);
      push_page(4'h7, "R4 unchanged");

      // R10 repeated start
      bus_start(); xfer(SEL, ack); xfer(8'h74, ack); xfer(8'h11, ack);
      bus_start(); xfer(SEL, ack); check_eq("R10 sel ack", ack, 1);
      xfer(8'h80, ack); xfer(8'h22, ack); check_eq("R10 data ack", ack, 1);
      bus_stop(); model[8'h80] = 8'h22;
      wait (!busy); tick(2);
      push_page(4'h7, "R10 aborted");
      push_page(4'h8, "R10 second");

      // R9 deaf during busy
      bus_start(); xfer(SEL, ack); xfer(8'h90, ack); xfer(8'h5A, ack); bus_stop();
      model[8'h90] = 8'h5A;
      bus_start(); xfer(SEL, ack);
      check_eq("R9 still busy", busy, 1);
      check_eq("R9 sel nak", ack, 0);
      xfer(8'h91, ack); xfer(8'h77, ack); bus_stop();
      wait (!busy); tick(4);
      check_eq("R9 no second busy", busy, 0);
      push_page(4'h9, "R9 deaf");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule